// File: doc/BRIEF.md
# Peripheral clock ratio divider

This block derives a peripheral clock from the processor clock with a ratio that is picked by a 2-bit control code. Software writes the code through a one-cycle write strobe and can read the accepted code back at any time. The divided clock comes out as a clock signal, `pclk_o`, and also as a one-cycle clock-enable pulse, `pclk_en_o`, for logic that stays on the processor clock.

The code mapping does not rise with the ratio. Code 00 divides by four, 01 passes the processor clock through and 10 divides by two. Code 11 is reserved: a write of it is dropped and the earlier setting stays in force. A new code is stored when it is written, but the divider only switches to it when the current divided period ends. This way the output never shows a shortened high or low phase.

Top module: `pclk_div`

## Requirements
- R1: Code 00 divides by four: each period lasts 4 processor cycles, with `pclk_o` high for the first 2 and low for the last 2.
- R2: Code 01 divides by one: `pclk_o` follows `clk_i`. It is high just after a rising edge of `clk_i` and low just after a falling edge.
- R3: Code 10 divides by two: each period lasts 2 processor cycles, with `pclk_o` high in the first and low in the second.
- R4: A write of code 11 is ignored. The read-back code and the running ratio keep their earlier values.
- R5: During and after reset the code is 00, and the divider sits in the first cycle of a divide-by-four period, with `pclk_en_o`=1 and `pclk_o`=1.
- R6: A newly accepted code takes effect only at the first period start that follows the clock edge that stored it. Until then the current period runs out at the old ratio.
- R7: `rd_data_o` always shows the last accepted code, which is 00, 01 or 10 and never 11. It updates on the clock edge that takes the write.
- R8: In divide-by-one mode `pclk_en_o` is high on every processor cycle.
- R9: `pclk_en_o` is high in exactly the first processor cycle of each divided period, which is the cycle in which `pclk_o` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Processor clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe for the control code, one cycle |
| wr_data_i | input | 2 | Control code to write: 00 = /4, 01 = /1, 10 = /2, 11 = reserved |
| rd_data_o | output | 2 | Last accepted control code |
| pclk_o | output | 1 | Divided peripheral clock |
| pclk_en_o | output | 1 | Enable pulse in the first processor cycle of each divided period |

## Verification
A write changes `rd_data_o` on the clock edge that samples it. The divider picks up the new code at the first period boundary after that edge, so the enable and the divided clock show it between 1 and 4 processor cycles later, depending on the phase the write lands in. The bench keeps a cycle-accurate arithmetic model of the code, the running ratio and the count within the period, updated on each rising edge. It compares the outputs 1 ns after each rising edge, and 1 ns after each falling edge so that the pass-through case is seen low. Every ordered pair of codes, including the reserved one, is written at shifting phases. A directed case checks that a write landing mid-period lets the old period finish before the new ratio starts.

// File: rtl/pclk_div_pkg.sv
package pclk_div_pkg;
  localparam int unsigned CODE_W  = 2;
  localparam int unsigned MAX_DIV = 4;
  localparam int unsigned CNT_W   = $clog2(MAX_DIV);

  typedef enum logic [CODE_W-1:0] {
    CODE_DIV4 = 2'b00,
    CODE_DIV1 = 2'b01,
    CODE_DIV2 = 2'b10,
    CODE_RSVD = 2'b11
  } ratio_code_e;

  // processor cycles per divided period
  function automatic logic [CNT_W:0] period_of(ratio_code_e code);
    case (code)
      CODE_DIV1: period_of = (CNT_W+1)'(1);
      CODE_DIV2: period_of = (CNT_W+1)'(2);
      default:   period_of = (CNT_W+1)'(MAX_DIV);
    endcase
  endfunction
endpackage

// File: rtl/pclk_div_ctrl.sv
module pclk_div_ctrl
  import pclk_div_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [CODE_W-1:0] wr_data_i,
  output ratio_code_e       code_o
);
  ratio_code_e code_q;
  logic        accept;

  assign accept = wr_en_i && (wr_data_i != CODE_RSVD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     code_q <= CODE_DIV4;
    else if (accept) code_q <= ratio_code_e'(wr_data_i);
  end

  assign code_o = code_q;

  p_reserved_kept_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i == CODE_RSVD) |=> $stable(code_o));
  p_accept_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i != CODE_RSVD) |=> (code_o == $past(wr_data_i)));
  p_never_reserved_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (code_o != CODE_RSVD));
endmodule

// File: rtl/pclk_div_gen.sv
module pclk_div_gen
  import pclk_div_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  ratio_code_e sel_i,
  output logic        pclk_o,
  output logic        pclk_en_o
);
  ratio_code_e      act_q, act_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             hi_q, hi_d, en_q, en_d;
  logic [CNT_W:0]   per_cur, per_nxt;
  logic             last;

  assign per_cur = period_of(act_q);
  assign last    = ({1'b0, cnt_q} == per_cur - 1'b1);

  always_comb begin
    act_d = act_q;
    cnt_d = cnt_q + 1'b1;
    if (last) begin
      cnt_d = '0;
      act_d = sel_i;  // ratio only swaps at a period boundary
    end
    per_nxt = period_of(act_d);
    en_d    = (cnt_d == '0);
    hi_d    = (act_d == CODE_DIV1) || ({1'b0, cnt_d} < (per_nxt >> 1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= CODE_DIV4;
      cnt_q <= '0;
      hi_q  <= 1'b1;
      en_q  <= 1'b1;
    end else begin
      act_q <= act_d;
      cnt_q <= cnt_d;
      hi_q  <= hi_d;
      en_q  <= en_d;
    end
  end

  // pass-through switch only moves at an edge where both sources are high
  assign pclk_o    = (act_q == CODE_DIV1) ? clk_i : hi_q;
  assign pclk_en_o = en_q;

  p_switch_on_boundary_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(act_q) |-> pclk_en_o);
  p_div1_always_en_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q == CODE_DIV1) |-> pclk_en_o);
  p_en_with_high_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pclk_en_o && act_q != CODE_DIV1) |-> hi_q);
  p_div4_low_after_high_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q == CODE_DIV4 && !hi_q && !pclk_en_o && $past(pclk_en_o)) |-> 1'b0);
endmodule

// File: rtl/pclk_div.sv
module pclk_div
  import pclk_div_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [CODE_W-1:0] wr_data_i,
  output logic [CODE_W-1:0] rd_data_o,
  output logic              pclk_o,
  output logic              pclk_en_o
);
  ratio_code_e code;

  pclk_div_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_data_i(wr_data_i),
    .code_o   (code)
  );

  pclk_div_gen u_gen (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sel_i    (code),
    .pclk_o   (pclk_o),
    .pclk_en_o(pclk_en_o)
  );

  assign rd_data_o = code;
endmodule

// File: tb/pclk_div_tb_top.sv
module pclk_div_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_data = 2'b00;
  logic [1:0] rd_data;
  logic       pclk, pclk_en;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit run_chk = 1'b0;

  // model state
  int ctrl_m = 0, act_m = 0, cnt_m = 0;

  always #5 clk = ~clk;

  pclk_div dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .pclk_o(pclk), .pclk_en_o(pclk_en)
  );

  function automatic int per(int c);
    return (c == 1) ? 1 : (c == 2) ? 2 : 4;
  endfunction

  function automatic string tag_of(int c);
    return (c == 1) ? "R2" : (c == 2) ? "R3" : "R1";
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_m <= 0; act_m <= 0; cnt_m <= 0;
    end else begin
      if (wr_en && wr_data != 2'b11) ctrl_m <= int'(wr_data);
      if (cnt_m == per(act_m) - 1) begin
        cnt_m <= 0;
        act_m <= ctrl_m;
      end else cnt_m <= cnt_m + 1;
    end
  end

  always @(posedge clk) begin
    if (run_chk) begin
      #1;
      chk("R7 readback", int'(rd_data), ctrl_m);
      chk((act_m == 1) ? "R8 enable" : "R9 enable", int'(pclk_en), (cnt_m == 0) ? 1 : 0);
      chk(tag_of(act_m), int'(pclk),
          (act_m == 1) ? 1 : ((cnt_m < per(act_m) / 2) ? 1 : 0));
      #5;
      chk({tag_of(act_m), " low phase"}, int'(pclk),
          (act_m == 1) ? 0 : ((cnt_m < per(act_m) / 2) ? 1 : 0));
    end
  end

  task automatic wr(logic [1:0] code);
    @(negedge clk);
    wr_en = 1'b1; wr_data = code;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #23;
    chk("R5 reset code", int'(rd_data), 0);
    chk("R5 reset enable", int'(pclk_en), 1);
    chk("R5 reset pclk", int'(pclk), 1);
    @(negedge clk);
    rst_n = 1'b1;
    run_chk = 1'b1;
    idle(9);

    // R6: write /2 in the second cycle of a /4 period
    do begin @(posedge clk); #1; end while (cnt_m != 1);
    wr(2'b10);
    #1;
    chk("R6 old ratio kept en", int'(pclk_en), 0);
    chk("R6 old ratio kept pclk", int'(pclk), 0);
    chk("R7 code stored", int'(rd_data), 2);
    @(posedge clk); #1;
    chk("R6 old period tail en", int'(pclk_en), 0);
    chk("R6 old period tail pclk", int'(pclk), 0);
    @(posedge clk); #1;
    chk("R6 new period start", int'(pclk_en), 1);
    @(posedge clk); #1;
    chk("R6 div2 second cycle", int'(pclk_en), 0);
    @(posedge clk); #1;
    chk("R6 div2 next start", int'(pclk_en), 1);

    // R4: reserved write leaves code alone
    wr(2'b11);
    #1;
    chk("R4 reserved ignored", int'(rd_data), 2);

    // sweep all ordered code pairs at shifting phases
    for (int a = 0; a < 4; a++) begin
      for (int b = 0; b < 4; b++) begin
        wr(2'(a));
        idle(5 + b);
        wr(2'(b));
        idle(7 + a);
      end
    end
    wr(2'b01);
    idle(6);
    wr(2'b11);
    idle(6);
    #1;
    chk("R4 reserved keeps div1", int'(rd_data), 1);
    run_chk = 1'b0;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule